// File: doc/BRIEF.md
# Keyboard and Terminal Register Port

This block is a small peripheral on an 8-bit processor bus. The bus has a 16-bit address, separate write and read data paths and a write enable. The block decodes three adjacent byte registers that start at a base address. Through them, software can poll an ASCII keyboard, fetch the pending key and send characters to a character terminal. A key source presents a byte whose top bit flags a pending key. The block answers a key fetch with an acknowledge level that the key source uses to release its buffer.

All reads are registered. The processor places an address, and the selected byte appears on the read data port after the next rising clock edge. Lowercase letters are folded to uppercase on the way in. Terminal writes leave as a single-cycle strobe with a 7-bit character.

Top module: `kbdterm_port`

## Requirements
- R1: A read (busWe low) of the key data register (base+0) returns the key byte one clock later, unchanged for every value outside the folding range of R2.
- R2: When the key byte of a key data read lies in 8'hE1..8'hFA (a pending 'a'..'z'), the returned byte is the key byte minus 8'h20, so bit 7 stays set. Neighbours 8'hE0 and 8'hFB, and lowercase codes with bit 7 clear, are not folded.
- R3: After a key data read, keyAck equals bit 7 of the key byte sampled on that read. keyAck holds its value until the next key data or key status read.
- R4: A read of the key status register (base+1) returns the key byte ANDed with 8'h80 and drives keyAck low.
- R5: A read of the terminal register (base+2) returns {~termReady, 7'b0}.
- R6: A write (busWe high) to base+2 raises termWe in the same cycle, with termChar equal to the written byte with bit 7 dropped. termWe is low in every other cycle.
- R7: A read of any other address, and any write cycle, returns 8'h00 on the read data port one clock later and leaves keyAck unchanged.
- R8: A synchronous reset clears the read data port and keyAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 16 | Processor address |
| busWrData | input | 8 | Processor write data |
| busWe | input | 1 | Write enable; low means read |
| busRdData | output | 8 | Registered read data |
| keyCode | input | 8 | Key byte, bit 7 means key pending |
| keyAck | output | 1 | Key acknowledge level |
| termReady | input | 1 | Terminal can accept a character |
| termWe | output | 1 | One-cycle terminal write strobe |
| termChar | output | 7 | Character to the terminal |

## Verification
The hardest state to reach is a raised keyAck that has to survive intervening traffic. It must stay high across unmapped reads and write cycles, and fall only on a status read. The bench fetches a pending key first. It then runs unrelated reads and a write to the key data address, and finally issues the status read, checking keyAck after each step. The folding edges are covered by a vector table holding the characters on both sides of the lowercase range, with and without the pending bit.

// File: rtl/kbdterm_pkg.sv
package kbdterm_pkg;
  // Decoded per-cycle strobes passed from control to datapath
  typedef struct packed {
    logic rdKeyData;
    logic rdKeyStat;
    logic rdTermStat;
    logic termWrite;
  } kbdStrobes_t;
endpackage

// File: rtl/kbdterm_ctrl.sv
module kbdterm_ctrl
  import kbdterm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hD010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output kbdStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] KEY_DATA_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] KEY_STAT_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TERM_ADDR     = BASE_ADDR + ADDR_W'(2);

  always_comb begin
    strb            = '0;
    strb.rdKeyData  = !busWe && (busAddr == KEY_DATA_ADDR);
    strb.rdKeyStat  = !busWe && (busAddr == KEY_STAT_ADDR);
    strb.rdTermStat = !busWe && (busAddr == TERM_ADDR);
    strb.termWrite  =  busWe && (busAddr == TERM_ADDR);
  end

  // R6
  term_write_only_on_we_chk: assert property (@(posedge clk) disable iff (rst)
    strb.termWrite |-> (busWe && busAddr == TERM_ADDR));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.rdKeyData, strb.rdKeyStat, strb.rdTermStat, strb.termWrite}));
endmodule

// File: rtl/kbdterm_dp.sv
module kbdterm_dp
  import kbdterm_pkg::*;
#(
  parameter int  DATA_W    = 8,
  parameter bit  FOLD_CASE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  kbdStrobes_t       strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] keyCode,
  input  logic              termReady,
  output logic [DATA_W-1:0] busRdData,
  output logic              keyAck,
  output logic              termWe,
  output logic [DATA_W-2:0] termChar
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] PEND_MASK = DATA_W'(1) << MSB;
  localparam logic [DATA_W-1:0] LOW_FIRST = PEND_MASK | DATA_W'(8'h61);
  localparam logic [DATA_W-1:0] LOW_LAST  = PEND_MASK | DATA_W'(8'h7A);
  localparam logic [DATA_W-1:0] CASE_GAP  = DATA_W'(8'h20);

  logic [DATA_W-1:0] keyFolded;
  logic              unusedWrMsb;

  generate
    if (FOLD_CASE) begin : g_fold
      always_comb
        keyFolded = (keyCode >= LOW_FIRST && keyCode <= LOW_LAST) ? keyCode - CASE_GAP : keyCode;
    end else begin : g_nofold
      always_comb keyFolded = keyCode;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busRdData <= '0;
      keyAck    <= 1'b0;
    end else if (strb.rdKeyData) begin
      busRdData <= keyFolded;
      keyAck    <= keyCode[MSB];
    end else if (strb.rdKeyStat) begin
      busRdData <= keyCode & PEND_MASK;
      keyAck    <= 1'b0;
    end else if (strb.rdTermStat) begin
      busRdData <= {!termReady, {(DATA_W-1){1'b0}}};
    end else begin
      busRdData <= '0;
    end
  end

  assign termWe      = strb.termWrite;
  assign termChar    = busWrData[MSB-1:0];
  assign unusedWrMsb = busWrData[MSB];

  // R3
  ack_rise_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(keyAck) |-> ($past(strb.rdKeyData) && $past(keyCode[MSB])));

  // R4
  ack_cleared_by_status_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rdKeyStat |=> !keyAck);

  // R5
  term_status_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rdTermStat |=> (busRdData[MSB-1:0] == '0));

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdKeyData || strb.rdKeyStat || strb.rdTermStat) |=> (busRdData == '0 && $stable(keyAck)));
endmodule

// File: rtl/kbdterm_port.sv
module kbdterm_port
  import kbdterm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hD010,
  parameter bit FOLD_CASE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] keyCode,
  output logic              keyAck,
  input  logic              termReady,
  output logic              termWe,
  output logic [DATA_W-2:0] termChar
);
  kbdStrobes_t strb;

  kbdterm_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) ctrl_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  kbdterm_dp #(.DATA_W(DATA_W), .FOLD_CASE(FOLD_CASE)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .busWrData(busWrData),
    .keyCode(keyCode), .termReady(termReady), .busRdData(busRdData),
    .keyAck(keyAck), .termWe(termWe), .termChar(termChar)
  );
endmodule

// File: tb/kbdterm_port_tb.sv
module kbdterm_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0]  busWrData = 8'h00;
  logic        busWe = 1'b0;
  logic [7:0]  busRdData;
  logic [7:0]  keyCode = 8'h00;
  logic        keyAck;
  logic        termReady = 1'b1;
  logic        termWe;
  logic [6:0]  termChar;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbdterm_port dut_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData), .busWe(busWe),
    .busRdData(busRdData), .keyCode(keyCode), .keyAck(keyAck),
    .termReady(termReady), .termWe(termWe), .termChar(termChar)
  );

  // {keyCode, expected read byte} for key data reads (R1, R2)
  localparam logic [15:0] FOLD_VEC [10] = '{
    16'h4141, 16'hC1C1, 16'hE1C1, 16'hFADA, 16'hE0E0,
    16'hFBFB, 16'h6161, 16'h0000, 16'hF0D0, 16'h7A7A
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic busCycle(input logic [15:0] a, input logic we, input logic [7:0] d);
    busAddr = a; busWe = we; busWrData = d;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R8 reset state
    chk("R8 rdData", busRdData, 8'h00);
    chk("R8 ack", {7'b0, keyAck}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 table walk
    for (int i = 0; i < 10; i++) begin
      keyCode = FOLD_VEC[i][15:8];
      busCycle(16'hD010, 1'b0, 8'h00);
      chk("R1/R2 key data", busRdData, FOLD_VEC[i][7:0]);
      chk("R3 ack", {7'b0, keyAck}, {7'b0, FOLD_VEC[i][15]});
    end

    // R4 status with and without pending key
    keyCode = 8'hC5;
    busCycle(16'hD011, 1'b0, 8'h00);
    chk("R4 status pending", busRdData, 8'h80);
    keyCode = 8'h45;
    busCycle(16'hD011, 1'b0, 8'h00);
    chk("R4 status idle", busRdData, 8'h00);

    // R3 R7 R4 acknowledge sequence
    keyCode = 8'hE1;
    busCycle(16'hD010, 1'b0, 8'h00);
    chk("R3 ack set", {7'b0, keyAck}, 8'h01);
    busCycle(16'hD013, 1'b0, 8'h00);
    chk("R7 unmapped rd", busRdData, 8'h00);
    chk("R7 ack held", {7'b0, keyAck}, 8'h01);
    keyCode = 8'h00;
    busCycle(16'hD010, 1'b1, 8'h55);
    chk("R7 write rd", busRdData, 8'h00);
    chk("R7 write ack held", {7'b0, keyAck}, 8'h01);
    busCycle(16'h0000, 1'b0, 8'h00);
    chk("R3 ack held", {7'b0, keyAck}, 8'h01);
    busCycle(16'hD011, 1'b0, 8'h00);
    chk("R4 ack cleared", {7'b0, keyAck}, 8'h00);

    // R5 terminal status
    termReady = 1'b1;
    busCycle(16'hD012, 1'b0, 8'h00);
    chk("R5 ready", busRdData, 8'h00);
    termReady = 1'b0;
    busCycle(16'hD012, 1'b0, 8'h00);
    chk("R5 busy", busRdData, 8'h80);

    // R6 terminal write strobe
    busAddr = 16'hD012; busWe = 1'b1; busWrData = 8'hC8;
    #2;
    chk("R6 termWe", {7'b0, termWe}, 8'h01);
    chk("R6 termChar", {1'b0, termChar}, 8'h48);
    @(negedge clk);
    busAddr = 16'hD012; busWe = 1'b0;
    #2;
    chk("R6 no we on read", {7'b0, termWe}, 8'h00);
    busAddr = 16'hD011; busWe = 1'b1;
    #2;
    chk("R6 no we other addr", {7'b0, termWe}, 8'h00);
    @(negedge clk);

    // R8 reset clears a raised ack
    keyCode = 8'hC1;
    busCycle(16'hD010, 1'b0, 8'h00);
    chk("R3 ack before reset", {7'b0, keyAck}, 8'h01);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 ack after reset", {7'b0, keyAck}, 8'h00);
    chk("R8 rd after reset", busRdData, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule